// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits between one processor core and a word-addressed data memory and gives the core an atomic read-modify-write primitive. The core issues two kinds of request: a linked load, which reads a word and places a reservation on its address, and a conditional store, which writes a word only if that reservation is still intact. The block has no storage for data. It passes the address and write data through to the memory and gates the memory write enable.

The block also watches the memory write port of every other agent that shares the memory. A foreign write to the reserved word breaks the reservation. A conditional store whose reservation has been broken does not write to memory, and the core receives 0 in place of the store's register value. A store that commits returns 1. The core uses this to build spin locks. It retries the load and store pair until the store reports 1.

Only one reservation is held: a valid flag and one word address. It is dropped by reset, by a clear input, by any conditional store, or by a matching foreign write.

Top module: `llsc_monitor`

## Requirements
- R1: A request with `req_op`=0 (linked load) returns the memory word at `req_addr` on `rsp_data` with `rsp_valid` high in the cycle after the request. `rsp_valid` is low in every cycle that follows a cycle with no request.
- R2: A request with `req_op`=1 (conditional store) succeeds when three conditions hold: the reservation is valid, its address equals `req_addr`, and no foreign write has hit that word. On success, `mem_we` is high in the same cycle, with `mem_addr`=`req_addr` and `mem_wdata`=`req_wdata`. In the next cycle `rsp_data` equals 1.
- R3: A conditional store that fails leaves `mem_we` low, and `rsp_data` equals 0 in the next cycle.
- R4: A foreign write (`snoop_we` high) to the reserved address clears the reservation. This includes a foreign write that arrives in the same cycle as the linked load that sets the reservation.
- R5: A conditional store to an address other than the reserved one fails.
- R6: Every conditional store clears the reservation, whether it succeeds or fails.
- R7: Reset and `res_clr` clear the reservation. When `res_clr` and a linked load arrive in the same cycle, no reservation is left.
- R8: A foreign write to the same word in the same cycle as a conditional store makes that store fail.
- R9: A new linked load replaces the existing reservation, so a store to the old address then fails.
- R10: A foreign write to any other word leaves the reservation intact.
- R11: While reset is held, `rsp_valid` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_clr | input | 1 | Drops the reservation |
| req_valid | input | 1 | Core request strobe |
| req_op | input | 1 | 0 = linked load, 1 = conditional store |
| req_addr | input | AW | Word address of the request |
| req_wdata | input | DW | Store data |
| snoop_we | input | 1 | Write strobe from another agent |
| snoop_addr | input | AW | Word address of that write |
| mem_rdata | input | DW | Combinational read data from memory at `mem_addr` |
| mem_we | output | 1 | Memory write enable, high only for a committing store |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_data | output | DW | Loaded word, or 1/0 outcome of a store |

## Verification
The reservation is hidden state, so any fault in it shows up only at the next conditional store. A flag left set wrongly appears as a spurious `mem_we` pulse in that store's cycle. A flag cleared wrongly appears as a 0 outcome one cycle later. The bench keeps addresses in a tiny range so that foreign writes, address mismatches and back-to-back stores often follow one another within a few cycles. It also runs a two-agent lock race, where a broken reservation shows up as a lost or duplicated lock grant in the bench's memory model.

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_clr,
  input  logic          req_valid,
  input  logic          req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          snoop_we,
  input  logic [AW-1:0] snoop_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  logic          held;
  logic [AW-1:0] held_addr;

  wire is_ld     = req_valid && !req_op;
  wire is_st     = req_valid && req_op;
  wire snoop_req = snoop_we && (snoop_addr == req_addr);
  wire snoop_res = snoop_we && (snoop_addr == held_addr);
  wire st_ok     = is_st && held && (held_addr == req_addr) && !snoop_req;

  assign mem_we    = st_ok;
  assign mem_addr  = req_addr;
  assign mem_wdata = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n || res_clr) begin
      held <= 1'b0;
    end else if (is_ld) begin
      held      <= !snoop_req;
      held_addr <= req_addr;
    end else if (is_st || snoop_res) begin
      held <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) rsp_data <= req_op ? DW'(st_ok) : mem_rdata;
    end
  end
endmodule

module llsc_monitor_chk #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          res_clr,
  input logic          req_valid,
  input logic          req_op,
  input logic [AW-1:0] req_addr,
  input logic          snoop_we,
  input logic [AW-1:0] snoop_addr,
  input logic          mem_we,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_data
);
  // R2
  we_only_on_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (req_valid && req_op));
  // R3
  store_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op) |=> (rsp_valid && rsp_data == DW'($past(mem_we))));
  // R6
  store_drops_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op) |=> !mem_we);
  // R7
  clear_drops_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_clr |=> !mem_we);
  // R8
  snoop_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_we && req_valid && req_op && snoop_addr == req_addr) |-> !mem_we);
endmodule

bind llsc_monitor llsc_monitor_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_clr(res_clr), .req_valid(req_valid),
  .req_op(req_op), .req_addr(req_addr), .snoop_we(snoop_we),
  .snoop_addr(snoop_addr), .mem_we(mem_we), .rsp_valid(rsp_valid),
  .rsp_data(rsp_data));

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;
  localparam int AW = 6;
  localparam int DW = 32;

  logic clk = 0;
  always #4 clk = ~clk;

  logic rst_n, res_clr, req_valid, req_op, snoop_we;
  logic [AW-1:0] req_addr, snoop_addr;
  logic [DW-1:0] req_wdata, snoop_wdata;
  logic mem_we, rsp_valid;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, rsp_data, mem_rdata;
  logic [DW-1:0] mem [2**AW];

  int n_chk = 0, n_bad = 0;

  llsc_monitor #(.AW(AW), .DW(DW)) dut (.*);

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    if (snoop_we) mem[snoop_addr] <= snoop_wdata;
    if (mem_we)   mem[mem_addr]   <= mem_wdata;
  end

  bit          m_v;
  logic [AW-1:0] m_a;
  bit          exp_rv;
  logic [DW-1:0] exp_rd;

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit pred_ok(logic op, logic [AW-1:0] a, logic sw, logic [AW-1:0] sa);
    return op && m_v && m_a == a && !(sw && sa == a);
  endfunction

  // one cycle: check previous response, drive, check mem_we, update model
  task automatic cyc(string req, logic v, logic op, logic [AW-1:0] a, logic [DW-1:0] d,
                     logic sw, logic [AW-1:0] sa, logic [DW-1:0] sd, logic clr);
    bit ok;
    @(negedge clk);
    check("R1 rsp_valid", DW'(rsp_valid), DW'(exp_rv));
    if (exp_rv) check({req, " rsp_data"}, rsp_data, exp_rd);
    req_valid = v; req_op = op; req_addr = a; req_wdata = d;
    snoop_we = sw; snoop_addr = sa; snoop_wdata = sd; res_clr = clr;
    #1;
    ok = v && pred_ok(op, a, sw, sa);
    check({req, " mem_we"}, DW'(mem_we), DW'(ok));
    if (ok) begin
      check("R2 mem_addr", DW'(mem_addr), DW'(a));
      check("R2 mem_wdata", mem_wdata, d);
    end
    exp_rv = v;
    if (v) exp_rd = op ? DW'(ok) : mem[a];
    if (clr) m_v = 0;
    else if (v && !op) begin m_v = !(sw && sa == a); m_a = a; end
    else if (v && op) m_v = 0;
    else if (sw && sa == m_a) m_v = 0;
  endtask

  task automatic idle();
    cyc("R1", 0, 0, '0, '0, 0, '0, '0, 0);
  endtask

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit a_has_lock, b_has_lock;
    void'($urandom(32'h5eed1));
    for (int i = 0; i < 2**AW; i++) mem[i] = DW'(i * 3 + 1);
    rst_n = 0; res_clr = 0; req_valid = 0; req_op = 0; req_addr = '0;
    req_wdata = '0; snoop_we = 0; snoop_addr = '0; snoop_wdata = '0;
    m_v = 0; m_a = '0; exp_rv = 0; exp_rd = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    req_valid = 1; req_op = 1; #1;
    check("R11 mem_we in reset", DW'(mem_we), 0);
    check("R11 rsp_valid in reset", DW'(rsp_valid), 0);
    req_valid = 0; req_op = 0;
    @(negedge clk); rst_n = 1;

    // R1/R2 basic pair
    cyc("R1", 1, 0, 6'd5, '0, 0, '0, '0, 0);
    cyc("R2", 1, 1, 6'd5, 32'hAB, 0, '0, '0, 0);
    // R6 second store without load
    cyc("R6", 1, 1, 6'd5, 32'hCD, 0, '0, '0, 0);
    // R4 snoop break
    cyc("R1", 1, 0, 6'd7, '0, 0, '0, '0, 0);
    cyc("R4", 0, 0, '0, '0, 1, 6'd7, 32'h77, 0);
    cyc("R4", 1, 1, 6'd7, 32'h1, 0, '0, '0, 0);
    // R4 snoop same cycle as load
    cyc("R4", 1, 0, 6'd8, '0, 1, 6'd8, 32'h88, 0);
    cyc("R4", 1, 1, 6'd8, 32'h2, 0, '0, '0, 0);
    // R5 mismatch
    cyc("R1", 1, 0, 6'd9, '0, 0, '0, '0, 0);
    cyc("R5", 1, 1, 6'd10, 32'h3, 0, '0, '0, 0);
    // R7 clear, and clear with load
    cyc("R1", 1, 0, 6'd11, '0, 0, '0, '0, 0);
    cyc("R7", 0, 0, '0, '0, 0, '0, '0, 1);
    cyc("R7", 1, 1, 6'd11, 32'h4, 0, '0, '0, 0);
    cyc("R7", 1, 0, 6'd12, '0, 0, '0, '0, 1);
    cyc("R7", 1, 1, 6'd12, 32'h5, 0, '0, '0, 0);
    // R8 same-cycle race
    cyc("R1", 1, 0, 6'd13, '0, 0, '0, '0, 0);
    cyc("R8", 1, 1, 6'd13, 32'h6, 1, 6'd13, 32'h99, 0);
    // R9 replacement
    cyc("R1", 1, 0, 6'd14, '0, 0, '0, '0, 0);
    cyc("R9", 1, 0, 6'd15, '0, 0, '0, '0, 0);
    cyc("R9", 1, 1, 6'd14, 32'h7, 0, '0, '0, 0);
    // R10 unrelated snoop
    cyc("R1", 1, 0, 6'd16, '0, 0, '0, '0, 0);
    cyc("R10", 0, 0, '0, '0, 1, 6'd17, 32'h55, 0);
    cyc("R10", 1, 1, 6'd16, 32'h8, 1, 6'd18, 32'h66, 0);
    idle();

    // lock race on word 20: 0 = free; core tags 1, other agent tags 2
    mem[20] = 0; a_has_lock = 0; b_has_lock = 0;
    cyc("R1", 1, 0, 6'd20, '0, 0, '0, '0, 0);
    cyc("R8", 1, 1, 6'd20, 32'h1, 1, 6'd20, 32'h2, 0);
    idle();
    check("R3 lock held by other", mem[20], 32'h2);
    cyc("R1", 0, 0, '0, '0, 1, 6'd20, 32'h0, 0);
    cyc("R1", 1, 0, 6'd20, '0, 0, '0, '0, 0);
    cyc("R2", 1, 1, 6'd20, 32'h1, 0, '0, '0, 0);
    idle();
    check("R2 lock taken by core", mem[20], 32'h1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic v, op, sw, clr;
      logic [AW-1:0] a, sa;
      v   = ($urandom % 4) != 0;
      op  = $urandom % 2;
      a   = AW'($urandom % 4);
      sw  = ($urandom % 4) == 0;
      sa  = AW'($urandom % 4);
      clr = ($urandom % 20) == 0;
      cyc(op ? "R2/R3" : "R1", v, op, a, $urandom, sw, sa, $urandom, clr);
    end
    idle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule